// File: doc/BRIEF.md
# Divergent Branch Predication Sequencer

This block steers a warp of lockstep lanes through a two-way conditional branch whose condition differs from lane to lane. When a branch is presented, it records the lanes' condition bits and the active mask at that moment. It then runs the side whose condition is true, with only those lanes enabled. After that it runs the opposite side with the complementary set of lanes enabled. Finally it returns the lanes to the mask they had before the branch.

While a path is running, the lanes are told which path is executing, and the block gates every per-lane result write with the current lane mask. Each lane therefore keeps only the result of the side it actually took. The instruction stream signals the end of a path with a one-cycle advance strobe.

The sequencer skips a path that no lane needs. It drops lanes that were already inactive from both paths, and it holds off a new branch until the current sequence has finished.

Top module: `branch_pred_seq`

## Requirements
- R1: After reset, `busy`, `done` and `path_sel` are 0, and `lane_mask` is all ones.
- R2: A branch is accepted on a clock edge where `br_valid` is 1 and `busy` is 0. On the next cycle `busy` is 1, `path_sel` is 1 (taken side) and `lane_mask` equals `br_cond & act_mask`.
- R3: When `step_adv` is 1 on a clock edge during the taken side and the other side is non-empty, the next cycle shows `path_sel` = 0 and `lane_mask` = `~br_cond & act_mask`, both taken from the values captured at acceptance.
- R4: When `step_adv` is 1 on a clock edge during the last needed path, the next cycle shows `busy` = 0, `path_sel` = 0 and `lane_mask` restored to the captured `act_mask`. `done` is 1 for exactly that one cycle.
- R5: If no active lane has its condition true, the taken side is skipped and the first path shown is the other side (`path_sel` = 0).
- R6: If every active lane has its condition true, the other side is skipped and one `step_adv` ends the sequence.
- R7: A branch accepted with an all-zero `act_mask` runs no path. The next cycle shows `busy` = 0, `done` = 1 and `lane_mask` = 0.
- R8: While `busy` is 1, `br_valid` has no effect on the mask, the path or the sequence.
- R9: `lane_wr_en` equals `lane_mask` ANDed with `res_valid` in every cycle.
- R10: During a path, `lane_mask` and `path_sel` stay unchanged on every edge where `step_adv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A divergent branch is presented this cycle |
| br_cond | input | LANES | Per-lane branch condition (1 = taken side) |
| act_mask | input | LANES | Active lanes at the branch |
| step_adv | input | 1 | Current path's instructions are complete |
| res_valid | input | LANES | Per-lane result produced this cycle |
| busy | output | 1 | A branch sequence is in progress |
| path_sel | output | 1 | 1 = taken side running, 0 = other side or none |
| lane_mask | output | LANES | Lanes enabled this cycle |
| lane_wr_en | output | LANES | Gated per-lane result write enables |
| done | output | 1 | One-cycle pulse when the sequence ends |

## Verification
Every registered result appears one clock edge after the edge that causes it. The mask and path select follow acceptance or `step_adv` by one edge, and `done` is high only in the cycle after the final advance. The bench drives inputs on the falling edge and samples on the next falling edge, which is exactly one rising edge later. It then samples once more to confirm that `done` has dropped. `lane_wr_en` is combinational, so it is checked in the same half cycle in which `res_valid` is applied.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TAKEN = 2'd1,
    ST_OTHER = 2'd2
  } bps_state_t;
endpackage

// File: rtl/bps_split.sv
module bps_split #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] cond,
  input  logic [LANES-1:0] act,
  output logic [LANES-1:0] take_m,
  output logic [LANES-1:0] rest_m,
  output logic             take_any,
  output logic             rest_any
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign take_m[i] = cond[i] & act[i];
    assign rest_m[i] = ~cond[i] & act[i];
  end
  assign take_any = |take_m;
  assign rest_any = |rest_m;
endmodule

// File: rtl/bps_fsm.sv
module bps_fsm
  import bps_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             step_adv,
  input  logic [LANES-1:0] act,
  input  logic [LANES-1:0] take_m,
  input  logic [LANES-1:0] rest_m,
  input  logic             take_any,
  input  logic             rest_any,
  output logic             busy,
  output logic             path_sel,
  output logic [LANES-1:0] lane_mask,
  output logic             done
);
  bps_state_t       st_q, st_d;
  logic [LANES-1:0] mask_q, mask_d;
  logic [LANES-1:0] home_q, home_d;
  logic [LANES-1:0] rest_q, rest_d;
  logic             done_d, done_q;
  logic             rest_ne_q, rest_ne_d;
  logic             upd_en;

  always_comb begin
    st_d      = st_q;
    mask_d    = mask_q;
    home_d    = home_q;
    rest_d    = rest_q;
    rest_ne_d = rest_ne_q;
    done_d    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          home_d    = act;
          rest_d    = rest_m;
          rest_ne_d = rest_any;
          if (take_any) begin
            st_d   = ST_TAKEN;
            mask_d = take_m;
          end else if (rest_any) begin
            st_d   = ST_OTHER;
            mask_d = rest_m;
          end else begin
            mask_d = act;
            done_d = 1'b1;
          end
        end
      end
      ST_TAKEN: begin
        if (step_adv) begin
          if (rest_ne_q) begin
            st_d   = ST_OTHER;
            mask_d = rest_q;
          end else begin
            st_d   = ST_IDLE;
            mask_d = home_q;
            done_d = 1'b1;
          end
        end
      end
      ST_OTHER: begin
        if (step_adv) begin
          st_d   = ST_IDLE;
          mask_d = home_q;
          done_d = 1'b1;
        end
      end
      default: begin
        st_d   = ST_IDLE;
        mask_d = home_q;
      end
    endcase
  end

  assign upd_en = accept | step_adv | (st_q != ST_IDLE) | done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      mask_q    <= '1;
      home_q    <= '1;
      rest_q    <= '0;
      rest_ne_q <= 1'b0;
      done_q    <= 1'b0;
    end else if (upd_en) begin
      st_q      <= st_d;
      mask_q    <= mask_d;
      home_q    <= home_d;
      rest_q    <= rest_d;
      rest_ne_q <= rest_ne_d;
      done_q    <= done_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign path_sel  = (st_q == ST_TAKEN);
  assign lane_mask = mask_q;
  assign done      = done_q;
endmodule

// File: rtl/branch_pred_seq.sv
module branch_pred_seq #(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_cond,
  input  logic [LANES-1:0] act_mask,
  input  logic             step_adv,
  input  logic [LANES-1:0] res_valid,
  output logic             busy,
  output logic             path_sel,
  output logic [LANES-1:0] lane_mask,
  output logic [LANES-1:0] lane_wr_en,
  output logic             done
);
  logic [LANES-1:0] take_m, rest_m;
  logic             take_any, rest_any;
  logic             accept;

  bps_split #(.LANES(LANES)) u_split (
    .cond(br_cond), .act(act_mask),
    .take_m(take_m), .rest_m(rest_m),
    .take_any(take_any), .rest_any(rest_any)
  );

  assign accept = br_valid & ~busy;

  bps_fsm #(.LANES(LANES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .step_adv(step_adv),
    .act(act_mask), .take_m(take_m), .rest_m(rest_m),
    .take_any(take_any), .rest_any(rest_any),
    .busy(busy), .path_sel(path_sel), .lane_mask(lane_mask), .done(done)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_wr
    assign lane_wr_en[i] = lane_mask[i] & res_valid[i];
  end
endmodule

// File: rtl/branch_pred_seq_chk.sv
module branch_pred_seq_chk #(
  parameter int LANES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_valid,
  input logic [LANES-1:0] act_mask,
  input logic             step_adv,
  input logic [LANES-1:0] res_valid,
  input logic             busy,
  input logic             path_sel,
  input logic [LANES-1:0] lane_mask,
  input logic [LANES-1:0] lane_wr_en,
  input logic             done
);
  // R2, R7: after acceptance no lane outside the incoming mask is enabled
  a_r2_mask_within_active: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !busy) |=> ((lane_mask & ~$past(act_mask)) == '0));

  // R4: done only when the sequence is over
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4: done is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: writes only on enabled lanes
  a_r9_wr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_wr_en & ~lane_mask) == '0);

  // R10 and R8: hold while busy without advance
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_adv) |=> ($stable(lane_mask) && $stable(path_sel) && busy));

  // R2: taken side only during a sequence
  a_r2_path_busy: assert property (@(posedge clk) disable iff (!rst_n)
    path_sel |-> busy);

  logic unused_ok;
  assign unused_ok = ^res_valid;
endmodule

bind branch_pred_seq branch_pred_seq_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .act_mask(act_mask),
  .step_adv(step_adv), .res_valid(res_valid), .busy(busy),
  .path_sel(path_sel), .lane_mask(lane_mask), .lane_wr_en(lane_wr_en),
  .done(done)
);

// File: tb/tb_branch_pred_seq.sv
module tb_branch_pred_seq;
  localparam int L = 32;
  logic clk, rst_n, br_valid, step_adv;
  logic [L-1:0] br_cond, act_mask, res_valid;
  logic busy, path_sel, done;
  logic [L-1:0] lane_mask, lane_wr_en;
  int errs, checks;

  branch_pred_seq #(.LANES(L)) dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_cond(br_cond),
    .act_mask(act_mask), .step_adv(step_adv), .res_valid(res_valid),
    .busy(busy), .path_sel(path_sel), .lane_mask(lane_mask),
    .lane_wr_en(lane_wr_en), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic st(input string tag, input logic b, input logic p, input logic d, input logic [L-1:0] m);
    chk({tag, " busy"}, {31'd0, busy}, {31'd0, b});
    chk({tag, " path_sel"}, {31'd0, path_sel}, {31'd0, p});
    chk({tag, " done"}, {31'd0, done}, {31'd0, d});
    chk({tag, " lane_mask"}, lane_mask, m);
  endtask

  task automatic give(input logic [L-1:0] c, input logic [L-1:0] m);
    br_valid = 1'b1; br_cond = c; act_mask = m;
    @(negedge clk);
    br_valid = 1'b0; br_cond = '0; act_mask = '0;
  endtask

  task automatic adv;
    step_adv = 1'b1;
    @(negedge clk);
    step_adv = 1'b0;
  endtask

  task automatic t_reset;
    st("R1 reset", 1'b0, 1'b0, 1'b0, '1);
  endtask

  task automatic t_full_split;
    logic [L-1:0] c = 32'hF0F0_1234, m = 32'hFFFF_00FF;
    give(c, m);
    st("R2 taken", 1'b1, 1'b1, 1'b0, c & m);
    @(negedge clk);
    st("R10 hold", 1'b1, 1'b1, 1'b0, c & m);
    res_valid = 32'h0F0F_FFFF;
    #1 chk("R9 wr_en", lane_wr_en, c & m & 32'h0F0F_FFFF);
    res_valid = '0;
    @(negedge clk);
    adv();
    st("R3 other", 1'b1, 1'b0, 1'b0, ~c & m);
    adv();
    st("R4 restore", 1'b0, 1'b0, 1'b1, m);
    @(negedge clk);
    st("R4 done drop", 1'b0, 1'b0, 1'b0, m);
  endtask

  task automatic t_skip_taken;
    logic [L-1:0] m = 32'h00FF_FF00;
    give(32'hFF00_00FF, m);
    st("R5 skip taken", 1'b1, 1'b0, 1'b0, m);
    adv();
    st("R5 end", 1'b0, 1'b0, 1'b1, m);
    @(negedge clk);
  endtask

  task automatic t_skip_other;
    logic [L-1:0] m = 32'h8000_0001;
    give(32'hC000_0003, m);
    st("R6 taken only", 1'b1, 1'b1, 1'b0, m);
    adv();
    st("R6 end", 1'b0, 1'b0, 1'b1, m);
    @(negedge clk);
  endtask

  task automatic t_empty;
    give(32'hFFFF_FFFF, '0);
    st("R7 empty", 1'b0, 1'b0, 1'b1, '0);
    @(negedge clk);
    st("R7 after", 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_busy_ignore;
    logic [L-1:0] c = 32'h0000_FFFF, m = 32'hFFFF_FFFF;
    give(c, m);
    give(32'hFFFF_0000, 32'h1234_5678);
    st("R8 ignore", 1'b1, 1'b1, 1'b0, c);
    adv();
    st("R8 other kept", 1'b1, 1'b0, 1'b0, ~c);
    adv();
    st("R8 restore", 1'b0, 1'b0, 1'b1, m);
    @(negedge clk);
  endtask

  initial begin
    errs = 0; checks = 0;
    br_valid = 0; step_adv = 0; br_cond = '0; act_mask = '0; res_valid = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_split();
    t_skip_taken();
    t_skip_other();
    t_empty();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule